// File: doc/BRIEF.md
# Auto-Reload PWM Capture Timer

This block is an 8-bit up-counter fed by a 7-bit prescaler. A two-bit field picks what clocks the prescaler: the internal clock, the internal clock divided by three, or rising edges of an external pin. The external pin passes through a two-flop synchroniser first. The counter has two modes. In auto-reload mode it restarts from a programmable reload value each time it passes FFh, so the reload value sets both the PWM period and the number of duty-cycle steps. In capture mode it wraps freely from FFh to 00h, and a selected edge on a capture pin stores the current count. The compare register controls the PWM output in both modes.

The PWM output goes high whenever the counter wraps and goes low when the counter reaches the compare value. It drives the pin only while the output-enable bit is set. Three sticky flags record overflow, compare match and capture. Each flag has its own interrupt enable, and software clears a flag by writing 0 to its bit.

Software uses a simple single-cycle write port and a combinational read port. The register addresses are: 0 mode, 1 prescaler/edge control, 2 reload, 3 compare, 4 capture (read only), 5 count, 6 flags.

Top module: `arpwm_timer`

## Requirements
- R1: After reset every register reads 00h, and both pwm_o and irq_o are 0.
- R2: Control register field bits[2:0] = k gives one tick per 2^k source pulses. Field bits[4:3] picks the source: 00 or 11 selects the internal clock (one pulse per cycle), 01 selects every third cycle, and 10 selects a synchronised rising edge of ext_clk_i. While the run bit (mode bit0) is 0, the counter holds and the prescaler and divide-by-three state clear to 0.
- R3: In auto-reload mode (mode bit1 = 0), a tick at count FFh loads the reload value, sets the overflow flag (flags bit0) and drives the PWM level high.
- R4: When a tick makes the new count equal the compare value, the PWM level goes low and the compare flag (flags bit1) is set. This takes priority over the high level set by a wrap on the same tick.
- R5: pwm_o carries the PWM level only while mode bit2 is 1, and is 0 otherwise.
- R6: In capture mode (mode bit1 = 1), a tick at FFh wraps the counter to 00h and sets the overflow flag; the reload value is not used.
- R7: In capture mode only, a synchronised edge on cap_i selected by control bits[6:5] (00 none, 01 rising, 10 falling, 11 both) copies the count into the capture register and sets the capture flag (flags bit2). In auto-reload mode the capture register does not change.
- R8: Writing the flags register clears each bit written as 0 and leaves each bit written as 1 unchanged. A flag being set in the same cycle takes priority over the clear.
- R9: irq_o is 1 exactly when some flag is set and its enable is set: mode bit3 for overflow, bit4 for compare, bit5 for capture.
- R10: Writing the count register loads the counter and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ext_clk_i | input | 1 | External prescaler source pin |
| cap_i | input | 1 | Capture trigger pin |
| pwm_o | output | 1 | Gated PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the embedded assertions check four things: the counter holds whenever there is no tick and no write, the next value after a wrap (reload value or zero, depending on mode), that a compare hit leaves the PWM level low, and that set flags and the capture register stay stable when nothing should change them. The bench scenarios cover what spans several cycles. They check exact tick counts for each prescaler ratio and source, the duty pattern from reload to compare, edge selection after the synchroniser delay, the read-back of write-to-clear flags, and interrupt gating.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
    typedef enum logic [2:0] {
        REG_MODE    = 3'd0,
        REG_CTL     = 3'd1,
        REG_RELOAD  = 3'd2,
        REG_COMPARE = 3'd3,
        REG_CAPTURE = 3'd4,
        REG_COUNT   = 3'd5,
        REG_FLAGS   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_DIV3 = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_ALT  = 2'd3
    } clk_src_e;

    // Mode register, bit5 down to bit0
    typedef struct packed {
        logic cap_ie;
        logic cmp_ie;
        logic ovf_ie;
        logic pwm_oe;
        logic cap_mode;
        logic run;
    } mode_t;

    localparam int MODE_W  = 6;
    localparam int FLAG_W  = 3;
    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_CAP = 2;
endpackage

// File: rtl/arpwm_sync.sv
module arpwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[STAGES-1];
        rise_o     = st_q.chain[STAGES-1] & ~st_q.prev;
        fall_o     = ~st_q.chain[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/arpwm_presc.sv
module arpwm_presc
    import arpwm_pkg::*;
#(
    parameter int PSC_W = 7,
    parameter int SEL_W = $clog2(PSC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  clk_src_e         src_i,
    input  logic [SEL_W-1:0] ratio_i,
    input  logic             ext_rise_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [1:0]       d3;
        logic [PSC_W-1:0] psc;
    } presc_t;

    presc_t           st_d, st_q;
    logic             src_pulse;
    logic [PSC_W-1:0] mask;

    always_comb begin
        unique case (src_i)
            SRC_DIV3: src_pulse = (st_q.d3 == 2'd2);
            SRC_EXT:  src_pulse = ext_rise_i;
            default:  src_pulse = 1'b1;
        endcase
        for (int i = 0; i < PSC_W; i++) begin
            mask[i] = (i < int'(ratio_i));
        end
        tick_o = run_i & src_pulse & ((st_q.psc & mask) == mask);

        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else begin
            st_d.d3 = (st_q.d3 == 2'd2) ? 2'd0 : st_q.d3 + 2'd1;
            if (src_pulse) st_d.psc = st_q.psc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q == '0)); // R2
endmodule

// File: rtl/arpwm_core.sv
module arpwm_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cap_mode_i,
    input  logic [W-1:0] reload_i,
    input  logic [W-1:0] compare_i,
    input  logic         cnt_wr_i,
    input  logic [W-1:0] cnt_wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o,
    output logic         ovf_set_o,
    output logic         cmp_set_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pwm;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ovf_set_o = 1'b0;
        cmp_set_o = 1'b0;
        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (tick_i) begin
            if (&st_q.cnt) begin
                st_d.cnt  = cap_mode_i ? '0 : reload_i;
                st_d.pwm  = 1'b1;
                ovf_set_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_d.cnt == compare_i) begin
                st_d.pwm  = 1'b0;
                cmp_set_o = 1'b1;
            end
        end
        cnt_o = st_q.cnt;
        pwm_o = st_q.pwm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(st_q.cnt)); // R2
    AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && !cap_mode_i && (&st_q.cnt)) |=> (st_q.cnt == $past(reload_i))); // R3
    AST_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_set_o |=> !st_q.pwm); // R4
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && cap_mode_i && (&st_q.cnt)) |=> (st_q.cnt == '0)); // R6
endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
    import arpwm_pkg::*;
#(
    parameter int W       = 8,
    parameter int PSC_W   = 7,
    parameter int SYNC_ST = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         ext_clk_i,
    input  logic         cap_i,
    output logic         pwm_o,
    output logic         irq_o
);
    localparam int SEL_W   = $clog2(PSC_W + 1);
    localparam int SRC_LO  = SEL_W;
    localparam int EDGE_LO = SEL_W + 2;
    localparam int CTL_W   = SEL_W + 4;

    typedef struct packed {
        mode_t              mode;
        logic [CTL_W-1:0]   ctl;
        logic [W-1:0]       reload;
        logic [W-1:0]       compare;
        logic [W-1:0]       capture;
        logic [FLAG_W-1:0]  flags;
    } regs_t;

    regs_t        rg_d, rg_q;
    logic         tick, ext_rise, ext_fall, cap_rise, cap_fall;
    logic         pwm_lvl, ovf_set, cmp_set, cap_fire;
    logic [W-1:0] cnt;
    logic         cnt_wr;
    logic [1:0]   edge_sel;
    logic [FLAG_W-1:0] set_vec, ie_vec;

    // One synchroniser per asynchronous pin
    for (genvar g = 0; g < 2; g++) begin : g_sync
        if (g == 0) begin : g_ext
            arpwm_sync #(.STAGES(SYNC_ST)) u_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i),
                .rise_o(ext_rise), .fall_o(ext_fall));
        end else begin : g_cap
            arpwm_sync #(.STAGES(SYNC_ST)) u_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(cap_i),
                .rise_o(cap_rise), .fall_o(cap_fall));
        end
    end

    arpwm_presc #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .run_i(rg_q.mode.run),
        .src_i(clk_src_e'(rg_q.ctl[SRC_LO +: 2])),
        .ratio_i(rg_q.ctl[SEL_W-1:0]),
        .ext_rise_i(ext_rise),
        .tick_o(tick));

    arpwm_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick),
        .cap_mode_i(rg_q.mode.cap_mode),
        .reload_i(rg_q.reload),
        .compare_i(rg_q.compare),
        .cnt_wr_i(cnt_wr),
        .cnt_wdata_i(wr_data),
        .cnt_o(cnt),
        .pwm_o(pwm_lvl),
        .ovf_set_o(ovf_set),
        .cmp_set_o(cmp_set));

    always_comb begin
        edge_sel = rg_q.ctl[EDGE_LO +: 2];
        cnt_wr   = wr_en && (wr_addr == REG_COUNT);
        cap_fire = rg_q.mode.cap_mode &&
                   ((edge_sel[0] && cap_rise) || (edge_sel[1] && cap_fall));
        set_vec  = '0;
        set_vec[FLG_OVF] = ovf_set;
        set_vec[FLG_CMP] = cmp_set;
        set_vec[FLG_CAP] = cap_fire;

        rg_d = rg_q;
        if (wr_en) begin
            unique case (wr_addr)
                REG_MODE:    rg_d.mode    = mode_t'(wr_data[MODE_W-1:0]);
                REG_CTL:     rg_d.ctl     = wr_data[CTL_W-1:0];
                REG_RELOAD:  rg_d.reload  = wr_data;
                REG_COMPARE: rg_d.compare = wr_data;
                REG_FLAGS:   rg_d.flags   = rg_q.flags & wr_data[FLAG_W-1:0];
                default: ;
            endcase
        end
        rg_d.flags = rg_d.flags | set_vec;
        if (cap_fire) rg_d.capture = cnt;

        ie_vec          = '0;
        ie_vec[FLG_OVF] = rg_q.mode.ovf_ie;
        ie_vec[FLG_CMP] = rg_q.mode.cmp_ie;
        ie_vec[FLG_CAP] = rg_q.mode.cap_ie;
        irq_o = |(rg_q.flags & ie_vec);
        pwm_o = pwm_lvl & rg_q.mode.pwm_oe;

        rd_data = '0;
        unique case (rd_addr)
            REG_MODE:    rd_data[MODE_W-1:0] = rg_q.mode;
            REG_CTL:     rd_data[CTL_W-1:0]  = rg_q.ctl;
            REG_RELOAD:  rd_data             = rg_q.reload;
            REG_COMPARE: rd_data             = rg_q.compare;
            REG_CAPTURE: rd_data             = rg_q.capture;
            REG_COUNT:   rd_data             = cnt;
            REG_FLAGS:   rd_data[FLAG_W-1:0] = rg_q.flags;
            default:     rd_data             = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (rg_q.flags[f] && !(wr_en && wr_addr == REG_FLAGS && !wr_data[f]))
            |=> rg_q.flags[f]); // R8
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.mode.cap_mode |=> $stable(rg_q.capture)); // R7
endmodule

// File: tb/arpwm_timer_tb_top.sv
module arpwm_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk_i = 1'b0;
    logic       cap_i = 1'b0;
    logic       pwm_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      req;
        int         kind;   // 0 read data, 1 pwm pin, 2 irq pin
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    arpwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk_i(ext_clk_i), .cap_i(cap_i), .pwm_o(pwm_o), .irq_o(irq_o));

    // Monitor: pops expected items and compares against observed outputs
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {7'd0, pwm_o};
                default: act = {7'd0, irq_o};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_item(input string req, input int kind, input logic [2:0] a,
                               input logic [7:0] e);
        item_t it;
        @(posedge clk); #1;
        rd_addr = a;
        it.req = req; it.kind = kind; it.exp = e;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Run for m idle cycles between a run write and a stop write: m+2 ticking edges
    task automatic run_for(input logic [7:0] run_mode, input int m, input logic [7:0] stop_mode);
        wr(3'd0, run_mode);
        repeat (m) @(posedge clk);
        wr(3'd0, stop_mode);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pin_cap(input logic v);
        @(posedge clk); #1;
        cap_i = v;
        idle(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item("R1 mode", 0, 3'd0, 8'h00);
        expect_item("R1 ctl", 0, 3'd1, 8'h00);
        expect_item("R1 count", 0, 3'd5, 8'h00);
        expect_item("R1 flags", 0, 3'd6, 8'h00);
        expect_item("R1 pwm", 1, 3'd0, 8'h00);
        expect_item("R1 irq", 2, 3'd0, 8'h00);

        // R3 auto-reload: FE -> FF -> reload
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h80);
        wr(3'd5, 8'hFE);
        run_for(8'h05, 0, 8'h04);
        expect_item("R3 count reload", 0, 3'd5, 8'h40);
        expect_item("R3 overflow flag", 0, 3'd6, 8'h01);
        expect_item("R3 pwm high", 1, 3'd0, 8'h01);

        // R5 output gating
        wr(3'd0, 8'h00);
        expect_item("R5 gated low", 1, 3'd0, 8'h00);
        wr(3'd0, 8'h04);
        expect_item("R5 enabled high", 1, 3'd0, 8'h01);

        // R8 write-1 keeps, write-0 clears
        wr(3'd6, 8'hFF);
        expect_item("R8 write ones keep", 0, 3'd6, 8'h01);
        wr(3'd6, 8'h00);
        expect_item("R8 write zero clear", 0, 3'd6, 8'h00);

        // R4 compare: FE -> FF -> 40 -> 41
        wr(3'd3, 8'h41);
        wr(3'd5, 8'hFE);
        run_for(8'h05, 1, 8'h04);
        expect_item("R4 count", 0, 3'd5, 8'h41);
        expect_item("R4 flags", 0, 3'd6, 8'h03);
        expect_item("R4 pwm low", 1, 3'd0, 8'h00);

        // R4 compare equals reload: low wins over wrap-high
        wr(3'd6, 8'h00);
        wr(3'd3, 8'h40);
        wr(3'd5, 8'hFE);
        run_for(8'h05, 0, 8'h04);
        expect_item("R4 priority pwm", 1, 3'd0, 8'h00);
        expect_item("R4 priority flags", 0, 3'd6, 8'h03);

        // R9 interrupt gating
        wr(3'd0, 8'h08);
        expect_item("R9 ovf enable", 2, 3'd0, 8'h01);
        wr(3'd0, 8'h20);
        expect_item("R9 cap enable only", 2, 3'd0, 8'h00);
        wr(3'd0, 8'h10);
        expect_item("R9 cmp enable", 2, 3'd0, 8'h01);
        wr(3'd6, 8'h00);
        expect_item("R9 cleared", 2, 3'd0, 8'h00);
        wr(3'd0, 8'h00);

        // R2 prescaler divide by 4
        wr(3'd3, 8'h80);
        wr(3'd1, 8'h02);
        wr(3'd5, 8'h10);
        run_for(8'h01, 6, 8'h00);
        expect_item("R2 div4 two ticks", 0, 3'd5, 8'h12);
        run_for(8'h01, 5, 8'h00);
        expect_item("R2 div4 one tick", 0, 3'd5, 8'h13);

        // R2 divide-by-three source
        wr(3'd1, 8'h08);
        wr(3'd5, 8'h20);
        run_for(8'h01, 4, 8'h00);
        expect_item("R2 div3 source", 0, 3'd5, 8'h22);

        // R2 external source: three rising edges
        wr(3'd1, 8'h10);
        wr(3'd5, 8'h30);
        wr(3'd0, 8'h01);
        for (int i = 0; i < 3; i++) begin
            ext_clk_i = 1'b1; idle(4);
            ext_clk_i = 1'b0; idle(4);
        end
        idle(6);
        wr(3'd0, 8'h00);
        expect_item("R2 external edges", 0, 3'd5, 8'h33);
        ext_clk_i = 1'b1; idle(4);
        ext_clk_i = 1'b0; idle(6);
        expect_item("R2 hold when stopped", 0, 3'd5, 8'h33);

        // R10 count write wins over tick
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        wr(3'd5, 8'h77);
        wr(3'd0, 8'h00);
        expect_item("R10 write then two ticks", 0, 3'd5, 8'h79);

        // R6 free-running wrap in capture mode
        wr(3'd6, 8'h00);
        wr(3'd5, 8'hFE);
        run_for(8'h03, 1, 8'h02);
        expect_item("R6 wrap to zero", 0, 3'd5, 8'h01);
        expect_item("R6 overflow flag", 0, 3'd6, 8'h01);

        // R7 edge selection, capture mode stopped
        wr(3'd6, 8'h00);
        wr(3'd1, 8'h20);
        wr(3'd5, 8'h37);
        pin_cap(1'b1);
        expect_item("R7 rising captured", 0, 3'd4, 8'h37);
        expect_item("R7 capture flag", 0, 3'd6, 8'h04);
        wr(3'd5, 8'h55);
        pin_cap(1'b0);
        expect_item("R7 falling ignored on rising sel", 0, 3'd4, 8'h37);
        wr(3'd1, 8'h40);
        pin_cap(1'b1);
        wr(3'd5, 8'h66);
        pin_cap(1'b0);
        expect_item("R7 falling captured", 0, 3'd4, 8'h66);
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h11);
        pin_cap(1'b1);
        pin_cap(1'b0);
        expect_item("R7 disabled edges", 0, 3'd4, 8'h66);
        wr(3'd1, 8'h60);
        wr(3'd5, 8'h21);
        pin_cap(1'b1);
        expect_item("R7 both rising", 0, 3'd4, 8'h21);
        wr(3'd5, 8'h22);
        pin_cap(1'b0);
        expect_item("R7 both falling", 0, 3'd4, 8'h22);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h99);
        pin_cap(1'b1);
        pin_cap(1'b0);
        expect_item("R7 reload mode no capture", 0, 3'd4, 8'h22);

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule